// File: doc/BRIEF.md
# Flash Command-Mode Read Selector

This block is the command-mode state machine of a flash memory device. It decides what a read returns. The choices are the plain array contents, identification bytes, or bytes from the device's self-description query table. Qualified write strobes come from the write qualifier, together with their address and data. The state machine decodes each strobe as a command and updates its mode register on that strobe's clock edge. A busy flag from the embedded program/erase engine blocks entry into the identification and query modes while an operation is running.

The registered mode goes to the device's read multiplexer on `mode_o`. The read data path is combinational from the current mode and the read address. In array mode it passes the array bytes through unchanged. In the two information modes it returns bytes from small tables that are computed in logic. The active-low reset models both the power-up reset and the supply-lockout reset. Either one forces the block back to array mode.

Top module: `cfi_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode_o` reads 0 (array mode). The only mode codes are 0 = array, 1 = identification and 2 = query, and code 3 never appears.
- R2: A strobe carrying data 98h at address 055h, in array mode with `busy` low, sets `mode_o` to 2 at the next clock edge.
- R3: A query or identification command strobed while `busy` is high leaves the mode unchanged.
- R4: A strobe carrying data 90h at address 555h, in array mode with `busy` low, sets `mode_o` to 1.
- R5: The query command (98h at 055h), strobed in identification mode with `busy` low, sets `mode_o` to 2.
- R6: Data F0h strobed at any address returns `mode_o` to 0 from identification or query mode, whatever the state of `busy`.
- R7: In query mode every strobe other than F0h data leaves the mode at 2, including the identification command.
- R8: In query mode, `rd_data` is 51h at read address 010h, 52h at 011h and 59h at 012h, and 00h at every other address.
- R9: In array mode, `rd_data` equals `array_data`.
- R10: In identification mode, `rd_data` is `MFR_ID` (default 01h) at address 000h, `DEV_ID` (default 7Eh) at address 001h, and 00h elsewhere.
- R11: The mode changes only at a clock edge on which `wr_stb` is high.
- R12: A strobe whose address or data differs from a command pattern does not enter query or identification mode. Examples are 98h at 056h and 97h at 055h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up / supply-lockout reset |
| wr_stb | input | 1 | Qualified write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Command data of the write |
| busy | input | 1 | Embedded program/erase in progress |
| rd_addr | input | ADDR_W | Read word address |
| array_data | input | DATA_W | Data from the memory array |
| mode_o | output | 2 | Registered read mode: 0 array, 1 identification, 2 query |
| rd_data | output | DATA_W | Read data selected by the mode |

## Verification
The assertions assume that `wr_stb` is already qualified and synchronous. They also assume that `busy` is a level that only changes between clock edges. The bench drives every input on the falling edge, pulses the strobe for exactly one cycle, and holds `busy` steady around each write. Because of this, each strobe is decoded exactly once against a known mode. Reads are sampled a full half-cycle after the mode register updates.

// File: rtl/cfi_mode_pkg.sv
package cfi_mode_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_QUERY = 2'd2
    } mode_e;

    localparam logic [7:0] CMD_QUERY = 8'h98;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_RESET = 8'hF0;
    localparam logic [11:0] ADR_QUERY = 12'h055;
    localparam logic [11:0] ADR_IDENT = 12'h555;

    typedef struct packed {
        logic is_query;
        logic is_ident;
        logic is_reset;
    } cmd_t;

    typedef struct packed {
        mode_e mode;
    } fsm_state_t;

    function automatic logic [7:0] query_byte(input logic [11:0] a);
        logic [7:0] r;
        case (a)
            12'h010: r = 8'h51;
            12'h011: r = 8'h52;
            12'h012: r = 8'h59;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfi_cmd_decode.sv
module cfi_cmd_decode
    import cfi_mode_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);
    localparam logic [ADDR_W-1:0] QADR = ADDR_W'(ADR_QUERY);
    localparam logic [ADDR_W-1:0] IADR = ADDR_W'(ADR_IDENT);
    localparam logic [DATA_W-1:0] QDAT = DATA_W'(CMD_QUERY);
    localparam logic [DATA_W-1:0] IDAT = DATA_W'(CMD_IDENT);
    localparam logic [DATA_W-1:0] RDAT = DATA_W'(CMD_RESET);

    always_comb begin
        cmd.is_query = (wr_data == QDAT) && (wr_addr == QADR);
        cmd.is_ident = (wr_data == IDAT) && (wr_addr == IADR);
        cmd.is_reset = (wr_data == RDAT);
    end

    always_comb begin
        assert ($countones({cmd.is_query, cmd.is_ident, cmd.is_reset}) <= 1)
            else $error("AST_ONE_CMD"); // R12
    end
endmodule

// File: rtl/cfi_mode_fsm.sv
module cfi_mode_fsm
    import cfi_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_stb,
    input  logic  busy,
    input  cmd_t  cmd,
    output mode_e mode
);
    fsm_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            if (cmd.is_reset) begin
                state_d.mode = MODE_ARRAY;
            end else if (!busy) begin
                case (state_q.mode)
                    MODE_ARRAY: begin
                        if (cmd.is_query)      state_d.mode = MODE_QUERY;
                        else if (cmd.is_ident) state_d.mode = MODE_IDENT;
                    end
                    MODE_IDENT: begin
                        if (cmd.is_query) state_d.mode = MODE_QUERY;
                    end
                    default: state_d.mode = state_q.mode;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{mode: MODE_ARRAY};
        else        state_q <= state_d;
    end

    assign mode = state_q.mode;

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.mode != 2'd3); // R1
    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(state_q.mode)); // R11
    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy && !cmd.is_reset) |=> $stable(state_q.mode)); // R3
    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && cmd.is_reset) |=> state_q.mode == MODE_ARRAY); // R6
    AST_QUERY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == MODE_QUERY && !(wr_stb && cmd.is_reset))
        |=> state_q.mode == MODE_QUERY); // R7
    AST_QUERY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode != MODE_QUERY && !(wr_stb && cmd.is_query && !busy))
        |=> state_q.mode != MODE_QUERY); // R12
endmodule

// File: rtl/cfi_info_table.sv
module cfi_info_table
    import cfi_mode_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter int          DATA_W = 8,
    parameter bit          IS_QUERY = 1'b1,
    parameter logic [7:0]  MFR_ID = 8'h01,
    parameter logic [7:0]  DEV_ID = 8'h7E
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] data
);
    logic [11:0] a12;
    assign a12 = 12'(rd_addr);

    generate
        if (IS_QUERY) begin : g_query
            logic wide_hi;
            if (ADDR_W > 12) begin : g_hi
                assign wide_hi = |rd_addr[ADDR_W-1:(ADDR_W > 12 ? 12 : 0)];
            end else begin : g_nohi
                assign wide_hi = 1'b0;
            end
            always_comb data = wide_hi ? '0 : DATA_W'(query_byte(a12));
        end else begin : g_ident
            always_comb begin
                if (rd_addr == ADDR_W'(0))      data = DATA_W'(MFR_ID);
                else if (rd_addr == ADDR_W'(1)) data = DATA_W'(DEV_ID);
                else                            data = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/cfi_mode_ctrl.sv
module cfi_mode_ctrl
    import cfi_mode_pkg::*;
#(
    parameter int         ADDR_W = 12,
    parameter int         DATA_W = 8,
    parameter logic [7:0] MFR_ID = 8'h01,
    parameter logic [7:0] DEV_ID = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_data,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] rd_data
);
    cmd_t              cmd;
    mode_e             mode;
    logic [DATA_W-1:0] qry_data, id_data;

    cfi_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd));

    cfi_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .busy(busy),
        .cmd(cmd), .mode(mode));

    cfi_info_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_QUERY(1'b1),
                     .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_qry (
        .rd_addr(rd_addr), .data(qry_data));

    cfi_info_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_QUERY(1'b0),
                     .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .rd_addr(rd_addr), .data(id_data));

    always_comb begin
        case (mode)
            MODE_QUERY: rd_data = qry_data;
            MODE_IDENT: rd_data = id_data;
            default:    rd_data = array_data;
        endcase
    end

    assign mode_o = mode;

    AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ARRAY) |-> rd_data == array_data); // R9
endmodule

// File: tb/cfi_mode_ctrl_tb.sv
module cfi_mode_ctrl_tb_top;
    localparam int AW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data = '0;
    logic [1:0]    mode_o;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfi_mode_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
        .array_data(array_data), .mode_o(mode_o), .rd_data(rd_data));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic b);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; busy = b;
        @(negedge clk);
        wr_stb = 1'b0; busy = 1'b0;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 mode during reset", mode_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after reset", mode_o, 0);
    endtask

    task automatic t_array_read();
        array_data = 8'hA5;
        rd("R9 array pass A5", 12'h010, 8'hA5);
        array_data = 8'h3C;
        rd("R9 array pass 3C", 12'h055, 8'h3C);
    endtask

    task automatic t_bad_patterns();
        wr(12'h056, 8'h98, 1'b0);
        chk("R12 98h at 056h", mode_o, 0);
        wr(12'h055, 8'h97, 1'b0);
        chk("R12 97h at 055h", mode_o, 0);
        wr(12'h055, 8'h90, 1'b0);
        chk("R12 90h at 055h", mode_o, 0);
    endtask

    task automatic t_busy();
        wr(12'h055, 8'h98, 1'b1);
        chk("R3 query while busy", mode_o, 0);
        wr(12'h555, 8'h90, 1'b1);
        chk("R3 ident while busy", mode_o, 0);
    endtask

    task automatic t_query_direct();
        wr(12'h055, 8'h98, 1'b0);
        chk("R2 enter query", mode_o, 2);
        array_data = 8'hEE;
        rd("R8 addr 010h", 12'h010, 8'h51);
        rd("R8 addr 011h", 12'h011, 8'h52);
        rd("R8 addr 012h", 12'h012, 8'h59);
        rd("R8 addr 013h", 12'h013, 8'h00);
        rd("R8 addr 000h", 12'h000, 8'h00);
        wr(12'h555, 8'h90, 1'b0);
        chk("R7 ident cmd in query", mode_o, 2);
        wr(12'h123, 8'h00, 1'b0);
        chk("R7 junk write in query", mode_o, 2);
        repeat (3) @(negedge clk);
        chk("R11 no strobe keeps mode", mode_o, 2);
        wr(12'h7AB, 8'hF0, 1'b1);
        chk("R6 reset from query while busy", mode_o, 0);
        rd("R9 array after reset", 12'h010, 8'hEE);
    endtask

    task automatic t_ident_path();
        wr(12'h555, 8'h90, 1'b0);
        chk("R4 enter ident", mode_o, 1);
        rd("R10 mfr id", 12'h000, 8'h01);
        rd("R10 dev id", 12'h001, 8'h7E);
        rd("R10 other addr", 12'h010, 8'h00);
        wr(12'h055, 8'h98, 1'b1);
        chk("R3 query from ident while busy", mode_o, 1);
        wr(12'h055, 8'h98, 1'b0);
        chk("R5 ident to query", mode_o, 2);
        wr(12'h000, 8'hF0, 1'b0);
        chk("R6 reset from query", mode_o, 0);
        wr(12'h555, 8'h90, 1'b0);
        wr(12'h001, 8'hF0, 1'b0);
        chk("R6 reset from ident", mode_o, 0);
    endtask

    task automatic t_power_reset();
        wr(12'h055, 8'h98, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        #1;
        chk("R1 lockout reset forces array", mode_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 array after lockout", mode_o, 0);
    endtask

    initial begin
        t_reset();
        t_array_read();
        t_bad_patterns();
        t_busy();
        t_query_direct();
        t_ident_path();
        t_power_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule